// File: doc/BRIEF.md
# Three-channel down-counting timer unit

This block is a register-mapped timer peripheral with three independent 32-bit down-counters. Each channel holds a live counter, a reload constant and a 16-bit control word that picks a prescaler ratio, enables an interrupt and carries a sticky underflow flag. A single shared start register holds one run bit per channel, so software starts and stops channels together or one at a time with a single write.

While its run bit is set, a channel counts down once per prescaled tick. When a tick finds the counter at zero, the counter reloads from its constant and the underflow flag is set. The flag is ANDed with the channel's interrupt enable to form a level interrupt, and it stays set until software writes a 0 into its bit. Register access uses a plain synchronous bus. A write takes effect at the clock edge on which it is presented. Read data is a combinational function of the address.

Top module: `tmr_unit`

## Requirements
- R1: After reset every run bit and every control word is 0. Every counter and every constant reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: Word addresses are decoded exactly. The start register is at offset 4, and bit n (n = 0..2) is channel n's run bit; its bits 7:3 read as 0. Channel n's constant is at 8+12n, its counter at 12+12n and its control word at 16+12n.
- R3: A running channel decrements its counter by one on each prescaled tick. A stopped channel's counter changes only when software writes it.
- R4: Control bits [2:0] set the tick period in input clocks: code 0 gives 4, 1 gives 16, 2 gives 64, 3 gives 256 and 4 gives 1024. Codes 5 to 7 give 4. The prescaler is held at zero while the channel is stopped, so the first tick comes exactly one period after the run bit is set.
- R5: A tick that finds the counter at 0 loads the counter from the constant register and sets the underflow flag (control bit 8).
- R6: The underflow flag is sticky. A control write with bit 8 = 0 clears it, a control write with bit 8 = 1 leaves it unchanged, and an underflow in the same cycle as a clearing write leaves it set.
- R7: Each channel's interrupt output is a level signal, high exactly when its underflow flag and its enable (control bit 5) are both 1.
- R8: Control reads return the prescaler code in bits [2:0], the enable in bit 5 and the flag in bit 8. All other bits read as 0.
- R9: The counter and the constant accept any 32-bit value. A counter write in the same cycle as a tick takes the written value, and that tick neither decrements the counter nor sets the flag.
- R10: Reads from any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The assertions check the counting rules on every cycle. They cover the decrement on a tick, the hold while stopped, the reload and flag set at zero, and the flag's stickiness without a control write. They also check that ticks never arrive back to back or while stopped, and that an enabled flag drives the interrupt on the next cycle. The exact prescaler periods, the address map, the readback masking, the reset values and the write-versus-tick priorities can only be shown by the bench's scenarios. The bench compares every register read and the interrupt lines against a cycle-stepped model that it builds from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PSC_W      = 10;
  localparam int CTL_W      = 16;
  localparam int CTL_IE_BIT = 5;
  localparam int CTL_UF_BIT = 8;
  localparam int START_OFS  = 4;
  localparam int BLK_BASE   = 8;
  localparam int BLK_STRIDE = 12;
  localparam int OFS_CNT    = 4;
  localparam int OFS_CTL    = 8;

  // terminal prescaler value (period - 1) for a control code
  function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] code);
    case (code)
      3'd1:    return PSC_W'(15);
      3'd2:    return PSC_W'(63);
      3'd3:    return PSC_W'(255);
      3'd4:    return PSC_W'(1023);
      default: return PSC_W'(3);
    endcase
  endfunction

  function automatic int blk_base(input int n);
    return BLK_BASE + BLK_STRIDE * n;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PSC_W-1:0] pc_q, pc_d;

  always_comb begin
    tick = run && (pc_q >= psc_limit(code));
    if (!run)      pc_d = '0;
    else if (tick) pc_d = '0;
    else           pc_d = pc_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cst_we,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    cnt_q,
  output logic [DW-1:0]    cst_q,
  output logic [CTL_W-1:0] ctl_rd,
  output logic             flag_q,
  output logic             ie_q,
  output logic             tick,
  output logic             irq
);
  logic [DW-1:0] cnt_d, cst_d;
  logic [2:0]    psc_q, psc_d;
  logic          ie_d, flag_d, uflow;

  tmr_prescaler u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (psc_q),
    .tick (tick)
  );

  always_comb begin
    cst_d = cst_we ? wdata : cst_q;
    cnt_d = cnt_q;
    uflow = 1'b0;
    if (cnt_we) begin
      cnt_d = wdata;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d = cst_q;
        uflow = 1'b1;
      end else begin
        cnt_d = cnt_q - DW'(1);
      end
    end
    psc_d  = ctl_we ? wdata[2:0] : psc_q;
    ie_d   = ctl_we ? wdata[CTL_IE_BIT] : ie_q;
    flag_d = flag_q;
    if (ctl_we) flag_d = flag_q & wdata[CTL_UF_BIT];
    if (uflow)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      cst_q  <= '1;
      psc_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cst_q  <= cst_d;
      psc_q  <= psc_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    ctl_rd             = '0;
    ctl_rd[2:0]        = psc_q;
    ctl_rd[CTL_IE_BIT] = ie_q;
    ctl_rd[CTL_UF_BIT] = flag_q;
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);
  logic             wr_en;
  logic [NCH-1:0]   start_q, start_d;
  logic             start_we;
  logic [NCH-1:0]   cst_we, cnt_we, ctl_we;
  logic [NCH-1:0]   ch_tick, ch_flag, ch_ie;
  logic [DW-1:0]    ch_cnt   [NCH];
  logic [DW-1:0]    ch_const [NCH];
  logic [CTL_W-1:0] ch_ctl   [NCH];

  assign wr_en    = bus_sel && bus_wr;
  assign start_we = wr_en && (bus_addr == AW'(START_OFS));
  assign start_d  = start_we ? bus_wdata[NCH-1:0] : start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else        start_q <= start_d;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int BASE = blk_base(n);
    assign cst_we[n] = wr_en && (bus_addr == AW'(BASE));
    assign cnt_we[n] = wr_en && (bus_addr == AW'(BASE + OFS_CNT));
    assign ctl_we[n] = wr_en && (bus_addr == AW'(BASE + OFS_CTL));

    tmr_channel #(.DW(DW)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (start_q[n]),
      .cst_we(cst_we[n]),
      .cnt_we(cnt_we[n]),
      .ctl_we(ctl_we[n]),
      .wdata (bus_wdata),
      .cnt_q (ch_cnt[n]),
      .cst_q (ch_const[n]),
      .ctl_rd(ch_ctl[n]),
      .flag_q(ch_flag[n]),
      .ie_q  (ch_ie[n]),
      .tick  (ch_tick[n]),
      .irq   (irq[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(START_OFS)) bus_rdata = DW'(start_q);
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(blk_base(n)))           bus_rdata = ch_const[n];
      if (bus_addr == AW'(blk_base(n) + OFS_CNT)) bus_rdata = ch_cnt[n];
      if (bus_addr == AW'(blk_base(n) + OFS_CTL)) bus_rdata = DW'(ch_ctl[n]);
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NCH = 3,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] tick,
  input logic [NCH-1:0] cnt_we,
  input logic [NCH-1:0] ctl_we,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] ie,
  input logic [NCH-1:0] irq,
  input logic [DW-1:0]  cnt [NCH],
  input logic [DW-1:0]  cst [NCH]
);
  for (genvar n = 0; n < NCH; n++) begin : g_a
    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[n] && !cnt_we[n] && cnt[n] != '0) |=> cnt[n] == $past(cnt[n]) - DW'(1));
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[n] && !cnt_we[n]) |=> $stable(cnt[n]));
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick[n] |=> !tick[n]);
    assert_no_tick_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run[n] |-> !tick[n]);
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[n] && !cnt_we[n] && cnt[n] == '0) |=> (cnt[n] == $past(cst[n]) && flag[n]));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[n] && !ctl_we[n]) |=> flag[n]);
    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[n] && ie[n] && !ctl_we[n]) |=> irq[n]);
  end
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (start_q),
  .tick  (ch_tick),
  .cnt_we(cnt_we),
  .ctl_we(ctl_we),
  .flag  (ch_flag),
  .ie    (ch_ie),
  .irq   (irq),
  .cnt   (ch_cnt),
  .cst   (ch_const)
);

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
  localparam int NCH = 3;
  localparam int DW  = 32;
  localparam int AW  = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_sel, bus_wr;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic [NCH-1:0] irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  tmr_unit #(.NCH(NCH), .DW(DW), .AW(AW)) i_tmr_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model, stepped once per clock from the requirements
  logic [DW-1:0]  m_cnt [NCH];
  logic [DW-1:0]  m_cst [NCH];
  logic [2:0]     m_psc [NCH];
  logic           m_ie  [NCH];
  logic           m_flag[NCH];
  int             m_pc  [NCH];
  logic [NCH-1:0] m_run;

  function automatic int f_div(input logic [2:0] code);
    case (code)
      3'd1: return 16;
      3'd2: return 64;
      3'd3: return 256;
      3'd4: return 1024;
      default: return 4;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = '0;
      for (int n = 0; n < NCH; n++) begin
        m_cnt[n] = '1; m_cst[n] = '1; m_psc[n] = '0;
        m_ie[n] = 1'b0; m_flag[n] = 1'b0; m_pc[n] = 0;
      end
    end else begin
      logic wr;
      wr = bus_sel && bus_wr;
      for (int n = 0; n < NCH; n++) begin
        int  base;
        logic tk, uf;
        base = 8 + 12 * n;
        tk = m_run[n] && (m_pc[n] >= f_div(m_psc[n]) - 1);
        m_pc[n] = (!m_run[n] || tk) ? 0 : m_pc[n] + 1;
        uf = 1'b0;
        if (wr && bus_addr == AW'(base + 4)) m_cnt[n] = bus_wdata;
        else if (tk) begin
          if (m_cnt[n] == '0) begin m_cnt[n] = m_cst[n]; uf = 1'b1; end
          else m_cnt[n] = m_cnt[n] - 1;
        end
        if (wr && bus_addr == AW'(base)) m_cst[n] = bus_wdata;
        if (wr && bus_addr == AW'(base + 8)) begin
          m_flag[n] = m_flag[n] & bus_wdata[8];
          m_psc[n]  = bus_wdata[2:0];
          m_ie[n]   = bus_wdata[5];
        end
        if (uf) m_flag[n] = 1'b1;
      end
      if (wr && bus_addr == AW'(4)) m_run = bus_wdata[NCH-1:0];
    end
  end

  function automatic logic [DW-1:0] f_exp(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    if (a == AW'(4)) v = DW'(m_run);
    for (int n = 0; n < NCH; n++) begin
      if (a == AW'(8 + 12 * n))  v = m_cst[n];
      if (a == AW'(12 + 12 * n)) v = m_cnt[n];
      if (a == AW'(16 + 12 * n)) v = DW'({m_flag[n], 2'b00, m_ie[n], 2'b00, m_psc[n]});
    end
    return v;
  endfunction

  function automatic logic [NCH-1:0] f_irq();
    logic [NCH-1:0] v;
    for (int n = 0; n < NCH; n++) v[n] = m_flag[n] & m_ie[n];
    return v;
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // read check against the model, plus interrupt lines
  task automatic chk(input string req, input logic [AW-1:0] a);
    logic [DW-1:0] e;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = a;
    #1;
    e = f_exp(a);
    n_checks++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read @%0d: actual %h expected %h", req, a, bus_rdata, e);
    end
    n_checks++;
    if (irq !== f_irq()) begin
      n_fail++;
      $display("FAIL R7 irq (%s): actual %b expected %b", req, irq, f_irq());
    end
  endtask

  // read check against a literal value
  task automatic chk_lit(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = a;
    #1;
    n_checks++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read @%0d: actual %h expected %h", req, a, bus_rdata, e);
    end
  endtask

  task automatic chk_irq_lit(input string req, input logic [NCH-1:0] e);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b", req, irq, e);
    end
  endtask

  function automatic logic [AW-1:0] pick_addr(input int k);
    case (k % 14)
      0: return AW'(4);
      1: return AW'(0);
      2: return AW'(44);
      3: return AW'(6);
      default: return AW'(8 + 4 * ((k % 14) - 4));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 / R2 reset values through the map
    chk_lit("R1", 8'd4, 32'h0);
    chk_lit("R1", 8'd12, 32'hFFFF_FFFF);
    chk_lit("R1", 8'd32, 32'hFFFF_FFFF);
    chk_lit("R1", 8'd40, 32'h0);
    chk_irq_lit("R1", 3'b000);
    for (int k = 0; k < 14; k++) chk("R2", pick_addr(k));

    // R5 / R7 directed underflow on channel 0, divide by 4
    bus_write(8'd8, 32'd3);
    bus_write(8'd12, 32'd1);
    bus_write(8'd16, 32'h20);
    bus_write(8'd4, 32'h1);
    repeat (7) @(posedge clk);
    chk_lit("R3", 8'd12, 32'd0);
    chk_irq_lit("R5", 3'b000);
    chk_lit("R5", 8'd16, 32'h120);
    chk_lit("R5", 8'd12, 32'd3);
    chk_irq_lit("R7", 3'b001);

    // R6 flag write-1 keeps, write-0 clears
    bus_write(8'd16, 32'h120);
    chk("R6", 8'd16);
    bus_write(8'd16, 32'h020);
    chk("R6", 8'd16);
    bus_write(8'd4, 32'h0);

    // R8 control readback masking, reserved prescaler code
    bus_write(8'd28, 32'hFFFF_FFFF);
    chk("R8", 8'd28);
    bus_write(8'd24, 32'd5);
    bus_write(8'd4, 32'h2);
    for (int k = 0; k < 6; k++) begin repeat (3) @(posedge clk); chk("R4", 8'd24); end

    // R4 divide by 16 on channel 2
    bus_write(8'd40, 32'h1);
    bus_write(8'd36, 32'd100);
    bus_write(8'd4, 32'h6);
    for (int k = 0; k < 8; k++) begin repeat (7) @(posedge clk); chk("R4", 8'd36); end

    // R9 counter written while running, any value
    bus_write(8'd36, 32'hFFFF_FFFF);
    chk("R9", 8'd36);
    bus_write(8'd32, 32'h0);
    chk("R9", 8'd32);

    // R10 unmapped writes change nothing
    bus_write(8'd0, 32'hFFFF_FFFF);
    bus_write(8'd44, 32'hFFFF_FFFF);
    bus_write(8'd13, 32'h0);
    for (int k = 0; k < 14; k++) chk("R10", pick_addr(k));

    // R3 stopped channel holds
    bus_write(8'd4, 32'h0);
    repeat (20) @(posedge clk);
    chk("R3", 8'd12);
    chk("R3", 8'd36);

    // constrained random mix
    for (int i = 0; i < 2500; i++) begin
      int r, ch;
      r  = int'($urandom % 8);
      ch = int'($urandom % NCH);
      case (r)
        0, 1: bus_write(AW'(12 + 12 * ch), ($urandom % 16 == 0) ? 32'hFFFF_FFFF : 32'($urandom % 6));
        2:    bus_write(AW'(8 + 12 * ch), 32'($urandom % 5));
        3:    bus_write(AW'(16 + 12 * ch), ($urandom & 32'h0000_FF20) | 32'($urandom % 8 < 5 ? ($urandom % 2) : $urandom % 8));
        4:    bus_write(8'd4, 32'($urandom % 256));
        5:    bus_write(AW'($urandom % 256), $urandom);
        default: repeat (1 + $urandom % 8) @(posedge clk);
      endcase
      chk((r < 2) ? "R9" : (r == 3) ? "R6" : (r == 5) ? "R10" : "R3", pick_addr(int'($urandom % 14)));
      if (i % 50 == 0) for (int n = 0; n < NCH; n++) chk("R5", AW'(16 + 12 * n));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule